// File: doc/BRIEF.md
# Key-Sequenced Pin Configuration Lock

This block is a 32-bit memory-mapped lock register for a 16-pin port. Software picks the pins to freeze by writing a mask. It then arms the lock with three full-word writes to the register. The key bit in these writes must go set, then cleared, then set again, and the mask must stay the same in all three. When the third write lands, the mask is latched and the key reads back as 1. From then on the register ignores every write until the next reset.

The block drives two per-pin vectors to a neighbouring configuration register bank. The first shows which pins are frozen. The second is a write permission for each pin's mode and alternate-function fields. A pin whose mask bit was 0 when the lock was taken stays configurable. Only writes to the lock address are checked against the key sequence. Bus traffic to other addresses between the steps leaves the sequence in progress.

Top module: `cfgLockReg`

## Requirements
- R1: The register layout is: bits 15:0 hold the mask, bit 16 is the key, and bits 31:17 read as 0. Read data is registered: it appears in the cycle after a read enable. A read of any other address returns 0.
- R2: After reset the readback is 0, no pin is frozen and every pin's write permission is 1.
- R3: Before the lock is taken, every write at the lock address with all four byte strobes set (4'hF) loads data bits 15:0 into the mask. The key bit reads 0 whatever value was written to it.
- R4: Three lock-address full-word writes with key values 1, 0, 1 and the same mask take the lock. The lock takes effect at the clock edge of the third write, and the key then reads 1.
- R5: A step whose mask differs from the mask written in the previous step aborts the sequence.
- R6: A lock-address write whose byte strobe is not 4'hF aborts the sequence and leaves the mask unchanged.
- R7: A key value that the current step does not expect resets the sequence. If that write carries key 1, it counts as a fresh first step. The lock is therefore taken exactly when the key values form the pattern 1,0,1 on consecutive lock-address full-word writes with an unchanged mask.
- R8: Writes to other addresses between the steps neither abort nor advance the sequence.
- R9: Once locked, writes to the register have no effect. Mask and key stay unchanged until reset.
- R10: The frozen-pin vector equals the mask while the lock is active and is 0 otherwise. Each pin's write permission is the inverse of its frozen bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (8) | Register address |
| busWrEn | input | 1 | Write enable |
| busRdEn | input | 1 | Read enable |
| busWrData | input | 32 | Write data |
| busByteEn | input | 4 | Byte strobes of the write |
| busRdData | output | 32 | Read data, registered |
| pinLocked | output | PIN_COUNT (16) | Frozen-pin vector |
| pinCfgWrOk | output | PIN_COUNT (16) | Per-pin permission to write mode and alternate-function fields |

## Verification
The bench sweeps every pattern of three and of four key values on lock-address writes. The expected lock result is computed arithmetically as the presence of the pattern 1,0,1 in the key values. This separates a correct sequencer from one that misses restarts on a repeated 1 or that locks on a partial pattern.

Directed runs cover the following cases, each of which must abort the sequence or leave it intact:
- a changed mask between steps;
- a partial byte strobe;
- interleaved writes to other addresses.

A walk of a single frozen pin across all sixteen positions shows that the write permission tracks the mask bit by bit. Writes issued after locking check that the mask and key are truly frozen.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SAW1  = 2'd1,
    SEQ_SAW10 = 2'd2
  } seqState_t;

  typedef struct packed {
    logic maskLoad;
    logic lockSet;
  } lockStrobe_t;

endpackage

// File: rtl/cfgLockCtrl.sv
module cfgLockCtrl
  import cfg_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrHit,
  input  logic        fullWord,
  input  logic        keyBit,
  input  logic        maskMatch,
  input  logic        lockActive,
  output lockStrobe_t strobe
);

  seqState_t state, stateNext;
  logic      stepWrite;

  // Only lock-address writes before locking are sequence steps.
  assign stepWrite = wrHit && !lockActive;

  always_comb begin
    stateNext = state;
    if (stepWrite) begin
      if (!fullWord) begin
        stateNext = SEQ_IDLE;
      end else begin
        unique case (state)
          SEQ_IDLE:  stateNext = keyBit ? SEQ_SAW1 : SEQ_IDLE;
          SEQ_SAW1:  stateNext = keyBit ? SEQ_SAW1 : (maskMatch ? SEQ_SAW10 : SEQ_IDLE);
          SEQ_SAW10: stateNext = keyBit ? SEQ_SAW1 : SEQ_IDLE;
          default:   stateNext = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.maskLoad = stepWrite && fullWord;
    strobe.lockSet  = stepWrite && fullWord && (state == SEQ_SAW10) && keyBit && maskMatch;
  end

endmodule

// File: rtl/cfgLockData.sv
module cfgLockData
  import cfg_lock_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lockStrobe_t          strobe,
  input  logic                 rdHit,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 keyBit,
  output logic                 maskMatch,
  output logic                 lockActive,
  output logic [PIN_COUNT-1:0] maskOut,
  output logic [DATA_W-1:0]    rdData
);

  localparam int KEY_POS = PIN_COUNT;
  localparam int RES_W   = DATA_W - PIN_COUNT - 1;

  logic [PIN_COUNT-1:0] maskReg;
  logic                 lockReg;

  assign keyBit    = wrData[KEY_POS];
  assign maskMatch = (wrData[PIN_COUNT-1:0] == maskReg);
  assign lockActive = lockReg;
  assign maskOut    = maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      lockReg <= 1'b0;
    end else begin
      if (strobe.maskLoad) maskReg <= wrData[PIN_COUNT-1:0];
      if (strobe.lockSet)  lockReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdData <= '0;
    else if (rdHit) rdData <= {{RES_W{1'b0}}, lockReg, maskReg};
    else            rdData <= '0;
  end

endmodule

// File: rtl/cfgLockReg.sv
module cfgLockReg
  import cfg_lock_pkg::*;
#(
  parameter int                PIN_COUNT = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h1C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [31:0]          busWrData,
  input  logic [3:0]           busByteEn,
  output logic [31:0]          busRdData,
  output logic [PIN_COUNT-1:0] pinLocked,
  output logic [PIN_COUNT-1:0] pinCfgWrOk
);

  localparam int DATA_W = 32;

  lockStrobe_t          strobe;
  logic                 wrHit, rdHit, fullWord;
  logic                 keyBit, maskMatch, lockActive;
  logic [PIN_COUNT-1:0] maskOut;

  assign wrHit    = busWrEn && (busAddr == LOCK_ADDR);
  assign rdHit    = busRdEn && (busAddr == LOCK_ADDR);
  assign fullWord = &busByteEn;

  cfgLockCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrHit      (wrHit),
    .fullWord   (fullWord),
    .keyBit     (keyBit),
    .maskMatch  (maskMatch),
    .lockActive (lockActive),
    .strobe     (strobe)
  );

  cfgLockData #(
    .PIN_COUNT (PIN_COUNT),
    .DATA_W    (DATA_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdHit      (rdHit),
    .wrData     (busWrData),
    .keyBit     (keyBit),
    .maskMatch  (maskMatch),
    .lockActive (lockActive),
    .maskOut    (maskOut),
    .rdData     (busRdData)
  );

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      assign pinLocked[p]  = lockActive & maskOut[p];
      assign pinCfgWrOk[p] = ~pinLocked[p];
    end
  endgenerate

endmodule

// File: rtl/cfgLockChecker.sv
module cfgLockChecker #(
  parameter int                PIN_COUNT = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h1C
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [31:0]          busWrData,
  input logic [3:0]           busByteEn,
  input logic [31:0]          busRdData,
  input logic [PIN_COUNT-1:0] pinLocked,
  input logic [PIN_COUNT-1:0] pinCfgWrOk,
  input logic                 lockActive
);

  // R1: reserved field always reads as zero
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[31:PIN_COUNT+1] == '0);

  // R10: without a lock every pin may be configured
  p_unlocked_writable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lockActive |-> (&pinCfgWrOk && pinLocked == '0));

  // R9: the lock and the frozen vector never change once taken
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> (lockActive && $stable(pinLocked)));

  // R4: the lock rises only on a full-word lock-address write carrying key 1
  p_lock_needs_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> $past(busWrEn && busAddr == LOCK_ADDR &&
                                busByteEn == 4'hF && busWrData[PIN_COUNT]));

  // R6: a partial-strobe write never completes the lock
  p_partial_no_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == LOCK_ADDR && busByteEn != 4'hF && !lockActive) |=> !lockActive);

endmodule

bind cfgLockReg cfgLockChecker #(
  .PIN_COUNT (PIN_COUNT),
  .ADDR_W    (ADDR_W),
  .LOCK_ADDR (LOCK_ADDR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busWrData  (busWrData),
  .busByteEn  (busByteEn),
  .busRdData  (busRdData),
  .pinLocked  (pinLocked),
  .pinCfgWrOk (pinCfgWrOk),
  .lockActive (lockActive)
);

// File: tb/test_cfgLockReg.sv
module test_cfgLockReg;

  localparam int        CLK_PERIOD = 10;
  localparam logic [7:0] LOCK_A  = 8'h1C;
  localparam logic [7:0] OTHER_A = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busRdData;
  logic [15:0] pinLocked, pinCfgWrOk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgLockReg i_cfgLockReg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busByteEn(busByteEn), .busRdData(busRdData),
    .pinLocked(pinLocked), .pinCfgWrOk(pinCfgWrOk)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  function automatic logic [31:0] keyWord(logic k, logic [15:0] m);
    return {15'h7FFF, k, m};
  endfunction

  // Expected outcome of a key sequence: the lock is taken iff 1,0,1 appears consecutively
  function automatic bit hasPattern(logic [3:0] keys, int n);
    for (int i = 0; i + 2 < n; i++)
      if (keys[i] && !keys[i+1] && keys[i+2]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] m;
    doReset();

    // R2: reset state
    rd(LOCK_A, r);
    check("R2 readback", r, 32'h0);
    check("R2 wrOk", {16'h0, pinCfgWrOk}, 32'h0000FFFF);

    // R3 / R1: mask loads, key reads 0, reserved reads 0
    wr(LOCK_A, keyWord(1'b1, 16'h1234), 4'hF);
    rd(LOCK_A, r);
    check("R3 R1 mask load, key 0", r, 32'h00001234);
    check("R10 unlocked wrOk", {16'h0, pinCfgWrOk}, 32'h0000FFFF);
    wr(LOCK_A, keyWord(1'b0, 16'hBEEF), 4'hF);
    rd(LOCK_A, r);
    check("R3 last written mask", r, 32'h0000BEEF);
    rd(OTHER_A, r);
    check("R1 other address reads 0", r, 32'h0);

    // R4 R7: sweep every 3- and 4-step key pattern
    for (int n = 3; n <= 4; n++) begin
      for (int k = 0; k < (1 << n); k++) begin
        logic [3:0] keys;
        bit expLock;
        keys = 4'(k);
        m = 16'hA5C3 ^ 16'(k * 37 + n);
        expLock = hasPattern(keys, n);
        doReset();
        for (int i = 0; i < n; i++) wr(LOCK_A, keyWord(keys[i], m), 4'hF);
        rd(LOCK_A, r);
        check("R4 R7 sweep readback", r, {15'h0, expLock, m});
        check("R7 R10 sweep pinLocked", {16'h0, pinLocked}, expLock ? {16'h0, m} : 32'h0);
        check("R10 sweep wrOk", {16'h0, pinCfgWrOk}, expLock ? {16'h0, ~m} : 32'h0000FFFF);
      end
    end

    // R5: mask change aborts
    doReset();
    wr(LOCK_A, keyWord(1'b1, 16'h00F0), 4'hF);
    wr(LOCK_A, keyWord(1'b0, 16'h0F00), 4'hF);
    wr(LOCK_A, keyWord(1'b1, 16'h0F00), 4'hF);
    rd(LOCK_A, r);
    check("R5 mask change step2", r, 32'h00000F00);
    doReset();
    wr(LOCK_A, keyWord(1'b1, 16'h00F0), 4'hF);
    wr(LOCK_A, keyWord(1'b0, 16'h00F0), 4'hF);
    wr(LOCK_A, keyWord(1'b1, 16'h0F0F), 4'hF);
    rd(LOCK_A, r);
    check("R5 mask change step3", r, 32'h00000F0F);

    // R6: partial strobe aborts and leaves the mask unchanged
    doReset();
    wr(LOCK_A, keyWord(1'b1, 16'h3C3C), 4'hF);
    wr(LOCK_A, keyWord(1'b0, 16'h3C3C), 4'hF);
    wr(LOCK_A, keyWord(1'b1, 16'hFFFF), 4'h7);
    rd(LOCK_A, r);
    check("R6 partial no lock, mask kept", r, 32'h00003C3C);
    wr(LOCK_A, keyWord(1'b1, 16'h3C3C), 4'hF);
    rd(LOCK_A, r);
    check("R6 sequence restarted", r, 32'h00003C3C);

    // R8: other-address writes between steps
    doReset();
    wr(LOCK_A, keyWord(1'b1, 16'h8001), 4'hF);
    wr(OTHER_A, 32'h0, 4'hF);
    wr(LOCK_A, keyWord(1'b0, 16'h8001), 4'hF);
    wr(OTHER_A, 32'hFFFFFFFF, 4'hF);
    wr(LOCK_A, keyWord(1'b1, 16'h8001), 4'hF);
    rd(LOCK_A, r);
    check("R8 interleaved lock", r, 32'h00018001);

    // R9: writes after lock have no effect
    wr(LOCK_A, keyWord(1'b0, 16'h0000), 4'hF);
    wr(LOCK_A, keyWord(1'b1, 16'h7FFE), 4'h3);
    rd(LOCK_A, r);
    check("R9 frozen readback", r, 32'h00018001);
    check("R9 R10 frozen wrOk", {16'h0, pinCfgWrOk}, 32'h00007FFE);

    // R10: walk a single frozen pin
    for (int p = 0; p < 16; p++) begin
      m = 16'(1 << p);
      doReset();
      wr(LOCK_A, keyWord(1'b1, m), 4'hF);
      wr(LOCK_A, keyWord(1'b0, m), 4'hF);
      wr(LOCK_A, keyWord(1'b1, m), 4'hF);
      @(negedge clk);
      check("R10 pin walk wrOk", {16'h0, pinCfgWrOk}, {16'h0, ~m});
      check("R10 pin walk locked", {16'h0, pinLocked}, {16'h0, m});
    end

    // R2: reset releases the lock
    doReset();
    rd(LOCK_A, r);
    check("R2 reset after lock", r, 32'h0);
    check("R2 wrOk after reset", {16'h0, pinCfgWrOk}, 32'h0000FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule